// File: doc/BRIEF.md
# Scan-out Fetch Address Generator

This block produces the stream of frame-buffer word addresses that a display refresh engine reads, one scan line per request. A frame strobe loads the frame's start offset and clears the displayed-line index. Each line strobe then issues a burst of consecutive word addresses, one per cycle, starting from the current line base. The base then moves on by the programmed pitch.

Three compatibility modes change the address stream, and each has its own one-bit enable. Split-screen compare forces the line whose displayed index matches a programmed value to start at address zero, and later lines walk on from zero. Chain-4 makes the in-line address advance by four words instead of one, so only every fourth 32-bit word is read. Line doubling makes each odd displayed line reuse the base of the even line before it, so the frame buffer holds half as many lines as are shown. The line index used for the split compare always counts displayed lines.

Top module: `scan_fetch_agen`

## Requirements
- R1: After reset, fetchValid is low, the displayed-line index is 0 and the line base is 0. A line strobe given without a prior frame strobe fetches from word address 0.
- R2: A line strobe sampled while idle makes fetchValid high for exactly wordsPerLine consecutive cycles, starting with the cycle after the sampling edge. When wordsPerLine is 0, no address is issued and the line still counts.
- R3: Inside a line, each address is the previous one plus 1 when chain4En is 0, and plus 4 when chain4En is 1. Addresses wrap modulo 2^ADDR_W.
- R4: A frame strobe clears the line index and loads frameOffset as the line base. It also ends any burst in progress, so fetchValid is low in the next cycle. If a line strobe comes in the same cycle, line 0 starts from frameOffset.
- R5: With all modes off, displayed line k starts at frameOffset + k*lineDelta.
- R6: With lineDblEn at 1, line 2m and line 2m+1 both start at frameOffset + m*lineDelta. The base advances only after odd lines.
- R7: With splitEn at 1, the line whose displayed index equals splitLine starts at address 0. Following lines advance from 0 by lineDelta, under the doubling rule in force.
- R8: The split compare uses the displayed line index, including when line doubling is on.
- R9: A line strobe that arrives while a burst is active is ignored. The burst is not restarted and the line index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame start strobe |
| lineStart | input | 1 | Line start strobe |
| frameOffset | input | ADDR_W | Word address where the frame begins |
| lineDelta | input | ADDR_W | Pitch between source lines, in words |
| wordsPerLine | input | WORDS_W | Number of fetches per line |
| splitLine | input | LINE_W | Displayed line index that restarts at address 0 |
| splitEn | input | 1 | Split-screen compare enable (1 = on) |
| chain4En | input | 1 | Chain-4 word skipping enable (1 = on) |
| lineDblEn | input | 1 | Line doubling enable (1 = on) |
| fetchAddr | output | ADDR_W | Fetch word address |
| fetchValid | output | 1 | fetchAddr is valid this cycle |

## Verification
A corrupted line base shows up in the first address of the next line burst, one cycle after its strobe. That error then carries into every later line of the frame. A wrong line index shows up as a split restart on the wrong line, or as a doubling pair shifted by one line. The bench sweeps whole frames through every mode mix and compares every issued address, so such faults appear within a few lines. A wrong word counter shows up as a burst one cycle too long or too short, seen directly on fetchValid.

// File: rtl/scan_fetch_pkg.sv
package scan_fetch_pkg;

  // Strobes passed from the control half to the address datapath
  typedef struct packed {
    logic loadFrame;  // load frame offset into the line base
    logic startLine;  // begin a new line burst this cycle
    logic zeroBase;   // this line restarts at address zero
    logic holdBase;   // next line reuses this line's base
    logic stepWord;   // advance the in-line address
  } fetch_strobe_t;

  localparam int unsigned CHAIN_STRIDE = 4;

endpackage

// File: rtl/scan_fetch_ctrl.sv
module scan_fetch_ctrl
  import scan_fetch_pkg::*;
#(
  parameter int unsigned LINE_W  = 10,
  parameter int unsigned WORDS_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic [WORDS_W-1:0] wordsPerLine,
  input  logic [LINE_W-1:0]  splitLine,
  input  logic               splitEn,
  input  logic               lineDblEn,
  output fetch_strobe_t      strobe,
  output logic               busy
);

  logic [LINE_W-1:0]  lineCnt;
  logic [LINE_W-1:0]  curLine;
  logic [WORDS_W-1:0] remaining;
  logic               startNow;
  logic               splitHit;

  // A frame strobe resets the index before a same-cycle line is decoded
  assign curLine  = frameStart ? '0 : lineCnt;
  // Overlapping line strobes are dropped unless a frame strobe aborts
  assign startNow = lineStart && (!busy || frameStart);
  assign splitHit = splitEn && (curLine == splitLine);

  always_comb begin
    strobe.loadFrame = frameStart;
    strobe.startLine = startNow;
    strobe.zeroBase  = splitHit;
    strobe.holdBase  = lineDblEn && !curLine[0];
    strobe.stepWord  = busy && !startNow && !frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt   <= '0;
      remaining <= '0;
      busy      <= 1'b0;
    end else begin
      if (startNow) begin
        lineCnt   <= curLine + 1'b1;
        remaining <= wordsPerLine;
        busy      <= (wordsPerLine != '0);
      end else if (frameStart) begin
        lineCnt   <= '0;
        remaining <= '0;
        busy      <= 1'b0;
      end else if (busy) begin
        remaining <= remaining - 1'b1;
        busy      <= (remaining != WORDS_W'(1));
      end
    end
  end

endmodule

// File: rtl/scan_fetch_dpath.sv
module scan_fetch_dpath
  import scan_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetch_strobe_t     strobe,
  input  logic [ADDR_W-1:0] frameOffset,
  input  logic [ADDR_W-1:0] lineDelta,
  input  logic              chain4En,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam logic [ADDR_W-1:0] STEP_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_WIDE = ADDR_W'(CHAIN_STRIDE);

  logic [ADDR_W-1:0] lineBase;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] effBase;
  logic [ADDR_W-1:0] stepAmt;

  always_comb begin
    if (strobe.zeroBase)       effBase = '0;
    else if (strobe.loadFrame) effBase = frameOffset;
    else                       effBase = lineBase;
  end

  assign stepAmt   = chain4En ? STEP_WIDE : STEP_ONE;
  assign fetchAddr = curAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBase <= '0;
      curAddr  <= '0;
    end else begin
      if (strobe.startLine) begin
        curAddr  <= effBase;
        lineBase <= strobe.holdBase ? effBase : effBase + lineDelta;
      end else begin
        if (strobe.loadFrame) lineBase <= frameOffset;
        if (strobe.stepWord)  curAddr  <= curAddr + stepAmt;
      end
    end
  end

endmodule

// File: rtl/scan_fetch_agen.sv
module scan_fetch_agen
  import scan_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned LINE_W  = 10,
  parameter int unsigned WORDS_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic [ADDR_W-1:0]  frameOffset,
  input  logic [ADDR_W-1:0]  lineDelta,
  input  logic [WORDS_W-1:0] wordsPerLine,
  input  logic [LINE_W-1:0]  splitLine,
  input  logic               splitEn,
  input  logic               chain4En,
  input  logic               lineDblEn,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic               fetchValid
);

  fetch_strobe_t strobe;

  scan_fetch_ctrl #(
    .LINE_W (LINE_W),
    .WORDS_W(WORDS_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameStart  (frameStart),
    .lineStart   (lineStart),
    .wordsPerLine(wordsPerLine),
    .splitLine   (splitLine),
    .splitEn     (splitEn),
    .lineDblEn   (lineDblEn),
    .strobe      (strobe),
    .busy        (fetchValid)
  );

  scan_fetch_dpath #(
    .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .frameOffset(frameOffset),
    .lineDelta  (lineDelta),
    .chain4En   (chain4En),
    .fetchAddr  (fetchAddr)
  );

endmodule

// File: rtl/scan_fetch_agen_chk.sv
module scan_fetch_agen_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned LINE_W  = 10,
  parameter int unsigned WORDS_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStart,
  input logic               lineStart,
  input logic [ADDR_W-1:0]  frameOffset,
  input logic [WORDS_W-1:0] wordsPerLine,
  input logic [LINE_W-1:0]  splitLine,
  input logic               splitEn,
  input logic               chain4En,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic               fetchValid
);

  logic [ADDR_W-1:0] expStep;
  assign expStep = chain4En ? ADDR_W'(4) : ADDR_W'(1);

  AST_WORD_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !frameStart) |=>
      (!fetchValid || fetchAddr == $past(fetchAddr) + $past(expStep))); // R3

  AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !lineStart) |=> !fetchValid); // R4

  AST_FRAME_FIRST_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && lineStart && wordsPerLine != '0 && !(splitEn && splitLine == '0))
      |=> (fetchValid && fetchAddr == $past(frameOffset))); // R4

  AST_LINE_BEGIN: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !fetchValid && wordsPerLine != '0) |=> fetchValid); // R2

  AST_EMPTY_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && (!fetchValid || frameStart) && wordsPerLine == '0) |=> !fetchValid); // R2

  AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && lineStart && wordsPerLine != '0 && splitEn && splitLine == '0)
      |=> (fetchValid && fetchAddr == '0)); // R7

endmodule

bind scan_fetch_agen scan_fetch_agen_chk #(
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_W),
  .WORDS_W(WORDS_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameStart  (frameStart),
  .lineStart   (lineStart),
  .frameOffset (frameOffset),
  .wordsPerLine(wordsPerLine),
  .splitLine   (splitLine),
  .splitEn     (splitEn),
  .chain4En    (chain4En),
  .fetchAddr   (fetchAddr),
  .fetchValid  (fetchValid)
);

// File: tb/scan_fetch_agen_tb.sv
module scan_fetch_agen_tb;

  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned LINE_W  = 6;
  localparam int unsigned WORDS_W = 4;
  localparam time         CLK_PERIOD = 10ns;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               frameStart = 1'b0;
  logic               lineStart = 1'b0;
  logic [ADDR_W-1:0]  frameOffset = '0;
  logic [ADDR_W-1:0]  lineDelta = '0;
  logic [WORDS_W-1:0] wordsPerLine = '0;
  logic [LINE_W-1:0]  splitLine = '0;
  logic               splitEn = 1'b0;
  logic               chain4En = 1'b0;
  logic               lineDblEn = 1'b0;
  logic [ADDR_W-1:0]  fetchAddr;
  logic               fetchValid;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_fetch_agen #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .WORDS_W(WORDS_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .frameOffset(frameOffset), .lineDelta(lineDelta), .wordsPerLine(wordsPerLine),
    .splitLine(splitLine), .splitEn(splitEn), .chain4En(chain4En),
    .lineDblEn(lineDblEn), .fetchAddr(fetchAddr), .fetchValid(fetchValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Start address of displayed line k, derived from the requirements
  function automatic int expBase(input int k, input bit dbl, input bit sp, input int s,
                                 input int off, input int delta);
    int from;
    int base;
    if (sp && k >= s) begin from = s; base = 0; end
    else begin from = 0; base = off; end
    for (int j = from; j < k; j++)
      if (!(dbl && (j % 2 == 0))) base += delta;
    return base & ((1 << ADDR_W) - 1);
  endfunction

  task automatic pulseFrame();
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
  endtask

  // Issue one line strobe and compare the whole burst
  task automatic runLine(input int base, input int n, input int step, input string req);
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    for (int w = 0; w < n; w++) begin
      int e;
      e = (base + w * step) & ((1 << ADDR_W) - 1);
      check(fetchValid === 1'b1, {req, " valid"}, int'(fetchValid), 1);
      check(fetchAddr === ADDR_W'(e), {req, " addr"}, int'(fetchAddr), e);
      @(negedge clk);
    end
    check(fetchValid === 1'b0, {req, " burst end"}, int'(fetchValid), 0);
  endtask

  task automatic runFrame(input bit c4, input bit dbl, input bit sp, input int s,
                          input int off, input int delta, input int n, input int lines);
    string req;
    if (sp && dbl)  req = "R8";
    else if (sp)    req = "R7";
    else if (dbl)   req = "R6";
    else if (c4)    req = "R3";
    else            req = "R5";
    @(negedge clk);
    chain4En = c4; lineDblEn = dbl; splitEn = sp; splitLine = LINE_W'(s);
    frameOffset = ADDR_W'(off); lineDelta = ADDR_W'(delta); wordsPerLine = WORDS_W'(n);
    pulseFrame();
    for (int k = 0; k < lines; k++)
      runLine(expBase(k, dbl, sp, s, off, delta), n, c4 ? 4 : 1, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fetchValid === 1'b0, "R1 reset valid", int'(fetchValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(fetchValid === 1'b0, "R1 idle after reset", int'(fetchValid), 0);
    wordsPerLine = 4'd3;
    lineDelta = 16'h0040;
    runLine(0, 3, 1, "R1 R2");
    // index advanced to 1 since reset: line 1 at delta
    runLine(16'h0040, 3, 1, "R1 R5");

    // Sweep every mode mix and several split positions
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 6; s++) begin
        runFrame(m[0], m[1], m[2], s, 16'h1000 + 16 * s, 16'h0050 + m, 2 + (s % 3), 8);
        if (!m[2]) break;
      end
    end

    // Zero-length line still counts as a line
    runFrame(1'b0, 1'b0, 1'b0, 0, 16'h0200, 16'h0010, 2, 1);
    wordsPerLine = 4'd0;
    runLine(0, 0, 1, "R2 empty line");
    wordsPerLine = 4'd2;
    runLine(16'h0220, 2, 1, "R2 count after empty");

    // Address wrap with chain-4
    runFrame(1'b1, 1'b0, 1'b0, 0, 16'hFFF8, 16'h0010, 4, 2);

    // Line strobe during a burst is ignored
    runFrame(1'b0, 1'b0, 1'b0, 0, 16'h0300, 16'h0020, 5, 1);
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    check(fetchAddr === 16'h0320, "R9 first", int'(fetchAddr), 16'h0320);
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    check(fetchAddr === 16'h0322, "R9 no restart", int'(fetchAddr), 16'h0322);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check(fetchValid === 1'b0, "R9 burst length", int'(fetchValid), 0);
    runLine(16'h0340, 5, 1, "R9 index not advanced");

    // Frame strobe aborts a burst
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    frameOffset = 16'h0500;
    frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    check(fetchValid === 1'b0, "R4 abort", int'(fetchValid), 0);
    runLine(16'h0500, 5, 1, "R4 reload");

    // Frame and line strobes together
    @(negedge clk) begin frameStart = 1'b1; lineStart = 1'b1; frameOffset = 16'h0700; end
    @(negedge clk) begin frameStart = 1'b0; lineStart = 1'b0; end
    check(fetchValid === 1'b1 && fetchAddr === 16'h0700, "R4 same-cycle line 0",
          int'(fetchAddr), 16'h0700);
    for (int i = 0; i < 5; i++) @(negedge clk);
    runLine(16'h0720, 5, 1, "R4 line 1 after combined");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule